// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer with one 32-bit control word, counted down by a slow tick strobe that arrives from outside the block. Software services it by writing the control word. The word carries a 7-bit key, a run command and a start count. Once the watchdog has been armed, the guard accepts a write only when that write's key is the bitwise inverse of the key already stored. A rogue write with a stale or random key therefore cannot keep the timer alive or stop it.

An accepted write stores the full word and reloads the down-counter from the count field, where a field of zero means 256 ticks. It then runs or halts the counter according to the command bit. If the count runs out, the block raises a non-maskable interrupt and starts a grace period of 10 ticks. If that grace period also runs out before an accepted write, the block raises a reset request. The reset request stays high until the block is reset.

The controller has four states. **ST_IDLE** means stopped. **ST_ARMED** means the first stage is counting. **ST_GRACE** means the interrupt is raised and the grace count is running. **ST_TRIPPED** means the reset request is held. Each transition has a name:

- *arm* (ST_IDLE to ST_ARMED): an accepted write with the command bit set.
- *first_expiry* (ST_ARMED to ST_GRACE): the count runs out.
- *second_expiry* (ST_GRACE to ST_TRIPPED): the grace count runs out.
- *service* (ST_ARMED or ST_GRACE to ST_ARMED): an accepted write with the command bit set.
- *halt* (ST_ARMED or ST_GRACE to ST_IDLE): an accepted write with the command bit clear.
- ST_TRIPPED is left only through reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the stored control word is 0, `nmi` and `reset_req` are low, and the counter is stopped.
- R2: The word fields are key = bits [15:9], run command = bit 8, count = bits [7:0]. While the stored bit 8 is 1, a write is ignored unless its key equals the bitwise inverse of the stored key. An ignored write leaves the control word, the count and the outputs unchanged.
- R3: While the stored bit 8 is 0 and the block is not tripped, every write is accepted whatever its key. The whole 32-bit word appears on `ctrl_word` one cycle after the write.
- R4: An accepted write with bit 8 = 1 loads a count N from bits [7:0], with 0 meaning 256. `nmi` rises at the clock edge that takes the N-th tick strobe after the write, and not before.
- R5: After an accepted write with bit 8 = 0, no number of tick strobes raises `nmi` or `reset_req`.
- R6: At the first expiry `nmi` rises and a grace count of 10 is loaded. With no accepted write in between, `reset_req` rises at the 10th tick after the first expiry, and `nmi` stays high.
- R7: An accepted write while `nmi` is high lowers `nmi` on the next cycle and restarts or halts the counter according to bit 8.
- R8: `reset_req` stays high until reset. While it is high, all writes are ignored.
- R9: When a write is accepted in the same cycle as a tick, the write wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe for the control word |
| wr_data | input | 32 | Control word being written |
| tick | input | 1 | One-cycle slow tick strobe (nominally 760 Hz) |
| ctrl_word | output | 32 | Currently stored control word |
| nmi | output | 1 | Non-maskable interrupt, first-stage expiry |
| reset_req | output | 1 | Sticky system reset request, second-stage expiry |

## Verification
The checker watches several rules on every cycle:

- A write rejected by the key leaves the stored word unchanged.
- A write while unlocked stores the full word.
- An accepted write clears the interrupt.
- The reset request is sticky and never appears without the interrupt.
- The interrupt only rises on a tick.

Only the directed scenarios can show that the exact number of ticks before each expiry is right. This covers the zero-means-256 load, the grace length of 10, and the write-over-tick priority, because those need a reference count of strobes since the last accepted write.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_GRACE,
        ST_TRIPPED
    } wd_state_e;
endpackage

// File: rtl/kwd_keycheck.sv
// Decides whether a control write is taken: always when unlocked,
// otherwise only with the inverted stored key; never once tripped.
module kwd_keycheck #(
    parameter int KEY_W = 7
) (
    input  logic             wr_en,
    input  logic             locked,
    input  logic             tripped,
    input  logic [KEY_W-1:0] new_key,
    input  logic [KEY_W-1:0] old_key,
    output logic             accept
);
    logic key_ok;

    always_comb begin
        key_ok = (new_key == ~old_key);
        accept = wr_en && !tripped && (!locked || key_ok);
    end
endmodule

// File: rtl/kwd_counter.sv
// Loadable down-counter; flags when the next decrement reaches zero.
module kwd_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb last = (cnt_q == CW'(1));
endmodule

// File: rtl/kwd_fsm.sv
// Expiry controller: idle, armed, grace, tripped.
module kwd_fsm
    import kwd_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int CW    = CNT_W + 1,
    parameter int GRACE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             run_cmd,
    input  logic [CNT_W-1:0] cnt_field,
    input  logic             tick,
    input  logic             last,
    output logic             load,
    output logic [CW-1:0]    load_val,
    output logic             dec,
    output logic             nmi,
    output logic             reset_req
);
    wd_state_e state_q, state_d;
    logic      running;
    logic      expire;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_ARMED) || (state_q == ST_GRACE);
        expire  = running && tick && last && !accept;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && run_cmd) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (accept)      state_d = run_cmd ? ST_ARMED : ST_IDLE;
                else if (expire) state_d = ST_GRACE;
            end
            ST_GRACE: begin
                if (accept)      state_d = run_cmd ? ST_ARMED : ST_IDLE;
                else if (expire) state_d = ST_TRIPPED;
            end
            ST_TRIPPED: begin
                state_d = ST_TRIPPED;
            end
        endcase
    end

    always_comb begin
        dec  = running && tick && !accept;
        load = accept || (expire && state_q == ST_ARMED);
        if (accept) begin
            load_val = (cnt_field == '0) ? (CW'(1) << CNT_W) : CW'(cnt_field);
        end else begin
            load_val = CW'(GRACE);
        end
        nmi       = (state_q == ST_GRACE) || (state_q == ST_TRIPPED);
        reset_req = (state_q == ST_TRIPPED);
    end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int KEY_W  = 7,
    parameter int GRACE  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              nmi,
    output logic              reset_req
);
    localparam int RUN_BIT = CNT_W;
    localparam int KEY_LO  = CNT_W + 1;
    localparam int KEY_HI  = KEY_LO + KEY_W - 1;
    localparam int CW      = CNT_W + 1;

    logic [DATA_W-1:0] ctrl_q;
    logic              accept;
    logic              load;
    logic [CW-1:0]     load_val;
    logic              dec;
    logic              last;

    kwd_keycheck #(.KEY_W(KEY_W)) u_key (
        .wr_en   (wr_en),
        .locked  (ctrl_q[RUN_BIT]),
        .tripped (reset_req),
        .new_key (wr_data[KEY_HI:KEY_LO]),
        .old_key (ctrl_q[KEY_HI:KEY_LO]),
        .accept  (accept)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (accept) ctrl_q <= wr_data;
    end

    kwd_fsm #(.CNT_W(CNT_W), .CW(CW), .GRACE(GRACE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .run_cmd   (wr_data[RUN_BIT]),
        .cnt_field (wr_data[CNT_W-1:0]),
        .tick      (tick),
        .last      (last),
        .load      (load),
        .load_val  (load_val),
        .dec       (dec),
        .nmi       (nmi),
        .reset_req (reset_req)
    );

    kwd_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .dec      (dec),
        .last     (last)
    );

    assign ctrl_word = ctrl_q;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int KEY_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick,
    input logic [DATA_W-1:0] ctrl_word,
    input logic              nmi,
    input logic              reset_req
);
    localparam int RUN_BIT = CNT_W;
    localparam int KEY_LO  = CNT_W + 1;
    localparam int KEY_HI  = KEY_LO + KEY_W - 1;

    logic bad_key;
    logic taken;
    always_comb begin
        bad_key = ctrl_word[RUN_BIT] && (wr_data[KEY_HI:KEY_LO] != ~ctrl_word[KEY_HI:KEY_LO]);
        taken   = wr_en && !reset_req && !bad_key;
    end

    AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bad_key) |=> $stable(ctrl_word)); // R2
    AST_OPEN_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reset_req && !ctrl_word[RUN_BIT]) |=> (ctrl_word == $past(wr_data))); // R3
    AST_NMI_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> $past(tick)); // R4
    AST_SERVICE_CLEARS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && taken) |=> !nmi); // R7
    AST_RESET_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(nmi)); // R6
    AST_RESET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (reset_req && nmi && $stable(ctrl_word))); // R8
endmodule

bind keyed_watchdog kwd_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_kwd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tick      (tick),
    .ctrl_word (ctrl_word),
    .nmi       (nmi),
    .reset_req (reset_req)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [31:0] ctrl_word;
    logic        nmi;
    logic        reset_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    keyed_watchdog u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .ctrl_word(ctrl_word), .nmi(nmi), .reset_req(reset_req)
    );

    function automatic logic [31:0] mk(input logic [6:0] key, input logic run, input logic [7:0] cnt);
        return {16'h0, key, run, cnt};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk("R1 ctrl", ctrl_word, 32'h0);
        chk("R1 nmi", {31'h0, nmi}, 32'h0);
        chk("R1 reset_req", {31'h0, reset_req}, 32'h0);
        ticks(300);
        chk("R1 stopped", {31'h0, nmi}, 32'h0);
    endtask

    task automatic t_open_and_stop();
        do_reset();
        do_write(32'hABCD_1234);
        chk("R3 stored", ctrl_word, 32'hABCD_1234);
        ticks(300);
        chk("R5 no nmi", {31'h0, nmi}, 32'h0);
        chk("R5 no reset", {31'h0, reset_req}, 32'h0);
    endtask

    task automatic t_full_expiry();
        do_reset();
        do_write(mk(7'h15, 1'b1, 8'd5));
        chk("R3 arm stored", ctrl_word, mk(7'h15, 1'b1, 8'd5));
        ticks(4);
        chk("R4 before N", {31'h0, nmi}, 32'h0);
        ticks(1);
        chk("R4 at N", {31'h0, nmi}, 32'h1);
        do_write(mk(7'h15, 1'b1, 8'd3));
        chk("R2 bad key ctrl", ctrl_word, mk(7'h15, 1'b1, 8'd5));
        chk("R2 bad key nmi", {31'h0, nmi}, 32'h1);
        do_write(mk(7'h6A, 1'b1, 8'd3));
        chk("R7 nmi cleared", {31'h0, nmi}, 32'h0);
        chk("R7 ctrl", ctrl_word, mk(7'h6A, 1'b1, 8'd3));
        ticks(2);
        chk("R4 reload before", {31'h0, nmi}, 32'h0);
        ticks(1);
        chk("R6 first expiry", {31'h0, nmi}, 32'h1);
        ticks(9);
        chk("R6 grace not over", {31'h0, reset_req}, 32'h0);
        ticks(1);
        chk("R6 reset_req", {31'h0, reset_req}, 32'h1);
        chk("R6 nmi held", {31'h0, nmi}, 32'h1);
        do_write(mk(7'h15, 1'b0, 8'd9));
        chk("R8 write ignored", ctrl_word, mk(7'h6A, 1'b1, 8'd3));
        ticks(3);
        chk("R8 sticky", {31'h0, reset_req}, 32'h1);
    endtask

    task automatic t_zero_means_256();
        do_reset();
        do_write(mk(7'h01, 1'b1, 8'd0));
        ticks(255);
        chk("R4 zero 255", {31'h0, nmi}, 32'h0);
        ticks(1);
        chk("R4 zero 256", {31'h0, nmi}, 32'h1);
        do_write(mk(7'h7E, 1'b0, 8'd4));
        chk("R7 halt nmi", {31'h0, nmi}, 32'h0);
        ticks(20);
        chk("R5 halted", {31'h0, nmi}, 32'h0);
        do_write(mk(7'h33, 1'b0, 8'd7));
        chk("R3 any key when open", ctrl_word, mk(7'h33, 1'b0, 8'd7));
    endtask

    task automatic t_write_beats_tick();
        do_reset();
        do_write(mk(7'h0F, 1'b1, 8'd2));
        ticks(1);
        @(negedge clk);
        wr_en = 1'b1; tick = 1'b1; wr_data = mk(7'h70, 1'b1, 8'd2);
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk("R9 no expiry", {31'h0, nmi}, 32'h0);
        ticks(1);
        chk("R9 tick not counted", {31'h0, nmi}, 32'h0);
        ticks(1);
        chk("R9 expiry after 2", {31'h0, nmi}, 32'h1);
    endtask

    initial begin
        t_reset_state();
        t_open_and_stop();
        t_full_expiry();
        t_zero_means_256();
        t_write_beats_tick();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule